// File: doc/BRIEF.md
# Almost-Empty / Almost-Full Offset Loader

This block keeps the two threshold offsets that a FIFO's flag logic compares against its fill level: the almost-empty distance and the almost-full distance. Both values appear on plain output buses in the clock domain of the flag logic (`clk`). A master reset loads both offsets from a table of eight preset values. A three-bit select input picks the entry, and the same value goes to both offsets.

After reset, software or a controller can replace the offsets in two ways. The first is a parallel path on the write data bus. It uses a valid/ready transfer in the `clk` domain, and each accepted word goes alternately to the almost-empty offset and then the almost-full offset. The second is a serial path with its own clock, enable and data pin. It shifts in the almost-empty value and then the almost-full value, least significant bit first. Each serially assembled value crosses into `clk` as a whole word through a toggle request and a synchronizer, so the flag logic never sees a half-written offset. Both paths are enabled only while the load input is high.

A partial reset returns both load sequences to their starting position and leaves the offsets unchanged.

Top module: `fop_offset_unit`

## Requirements
- R1: While `mrst` is sampled high on a `clk` edge, both offsets are loaded with 2^(s+3)-1, where s is the unsigned value of `dflt_sel`. This gives 7, 15, 31, 63, 127, 255, 511 or 1023 for s = 0 to 7.
- R2: A parallel transfer is accepted on a `clk` edge where `p_valid`, `p_ready` and `ld` are all high. Accepted words are written to the almost-empty offset, then the almost-full offset, alternating. The new value shows on the output after that edge.
- R3: A `p_valid` that is high while `ld` is low writes nothing and does not advance the alternation.
- R4: `p_ready` is low while `mrst` or `prst` is high, and for exactly one `clk` cycle when a serially loaded value is committed. At all other times it is high. A source that sees `p_ready` low must keep `p_valid` and `p_data` unchanged until it sees `p_ready` high.
- R5: A rising `sclk` edge shifts in `sdi` only when `ld` and `sen` are both high. The first OFS_W bits form the almost-empty offset and the next OFS_W bits form the almost-full offset, bit 0 first.
- R6: A serially completed offset reaches its output within 5 `clk` cycles of its last `sclk` edge. The output changes in a single step from the old value to the full new value.
- R7: After 2·OFS_W bits have been taken, further serial bits are ignored until the next `mrst` or `prst`.
- R8: Rising `sclk` edges while `sen` or `ld` is low change no offset and do not advance the serial bit count.
- R9: `prst` leaves both offsets unchanged. It returns the parallel alternation to almost-empty and the serial count to its first bit.
- R10: Outside master reset, an offset changes only through an accepted parallel word or a serial commit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock of the flag logic and of the parallel path |
| mrst | input | 1 | Master reset. Active high. Synchronous in the `clk` domain and asynchronous in the `sclk` domain |
| prst | input | 1 | Partial reset. Active high. Resets the load sequences only |
| dflt_sel | input | 3 | Selects the preset value that is loaded at master reset |
| ld | input | 1 | Load enable for both programming paths |
| p_valid | input | 1 | Parallel word is present on `p_data` |
| p_ready | output | 1 | Parallel word can be accepted this cycle |
| p_data | input | OFS_W | Parallel offset value |
| sclk | input | 1 | Serial programming clock |
| sen | input | 1 | Serial shift enable |
| sdi | input | 1 | Serial data in, least significant bit first |
| ae_ofs | output | OFS_W | Almost-empty offset, for the flag logic |
| af_ofs | output | OFS_W | Almost-full offset, for the flag logic |

## Verification
On every cycle, the assertions check four things: that master reset produces the preset pair, that offsets hold steady unless a write or commit takes place, that `ld` and partial reset block changes, and that a commit delivers exactly the word held by the serial side. Only the bench scenarios can show the following: the serial bit order, which register each half of the stream lands in, the saturation after 2·OFS_W bits, the alternation and its reset, and the full sweep of all eight presets. The bench also measures the one-cycle ready drop around a commit. It checks from the ports that `clk` never sees an intermediate serial value.

// File: rtl/fop_pkg.sv
package fop_pkg;

  typedef enum logic {
    SEL_AE = 1'b0,
    SEL_AF = 1'b1
  } ofs_sel_e;

  // preset table: 2^(code+3)-1, same value for both thresholds
  function automatic logic [31:0] preset_ofs(input logic [2:0] code);
    return (32'd1 << ({29'd0, code} + 32'd3)) - 32'd1;
  endfunction

endpackage

// File: rtl/fop_serial_shift.sv
module fop_serial_shift
  import fop_pkg::*;
#(
  parameter int W = 10
) (
  input  logic         sclk,
  input  logic         mrst,
  input  logic         prst,
  input  logic         ld,
  input  logic         sen,
  input  logic         sdi,
  output logic [W-1:0] hold_q,
  output ofs_sel_e     hold_sel_q,
  output logic         req_q
);

  localparam int CW = $clog2(2 * W + 1);
  localparam logic [CW-1:0] LAST_AE = CW'(W - 1);
  localparam logic [CW-1:0] LAST_AF = CW'(2 * W - 1);
  localparam logic [CW-1:0] DONE    = CW'(2 * W);

  logic [CW-1:0] cnt_q;
  logic [W-1:0]  sh_q;
  logic [W-1:0]  sh_next;
  logic          take;
  logic          word_end;

  assign take     = ld && sen && (cnt_q < DONE);
  assign sh_next  = {sdi, sh_q[W-1:1]};
  assign word_end = take && ((cnt_q == LAST_AE) || (cnt_q == LAST_AF));

  // bit counter: cleared by either reset, saturates at DONE
  always_ff @(posedge sclk or posedge mrst or posedge prst) begin
    if (mrst || prst) cnt_q <= '0;
    else if (take)    cnt_q <= cnt_q + 1'b1;
  end

  always_ff @(posedge sclk or posedge mrst) begin
    if (mrst) begin
      sh_q       <= '0;
      hold_q     <= '0;
      hold_sel_q <= SEL_AE;
      req_q      <= 1'b0;
    end else begin
      if (take) sh_q <= sh_next;
      if (word_end) begin
        hold_q     <= sh_next;
        hold_sel_q <= (cnt_q == LAST_AE) ? SEL_AE : SEL_AF;
        req_q      <= ~req_q;
      end
    end
  end

endmodule

// File: rtl/fop_sync_commit.sv
module fop_sync_commit #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic mrst,
  input  logic prst,
  input  logic req_async,
  output logic commit
);

  logic [STAGES-1:0] sync_q;
  logic              ack_q;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      always_ff @(posedge clk) begin
        if (mrst) sync_q[g] <= 1'b0;
        else if (g == 0) sync_q[g] <= req_async;
        else sync_q[g] <= sync_q[(g == 0) ? 0 : g-1];
      end
    end
  endgenerate

  // commit held off during either reset; taken once reset drops
  assign commit = (sync_q[STAGES-1] ^ ack_q) && !mrst && !prst;

  always_ff @(posedge clk) begin
    if (mrst)        ack_q <= 1'b0;
    else if (commit) ack_q <= sync_q[STAGES-1];
  end

endmodule

// File: rtl/fop_offset_regs.sv
module fop_offset_regs
  import fop_pkg::*;
#(
  parameter int W = 10
) (
  input  logic         clk,
  input  logic         mrst,
  input  logic         prst,
  input  logic [2:0]   dflt_sel,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  input  logic         cm_en,
  input  ofs_sel_e     cm_sel,
  input  logic [W-1:0] cm_data,
  output logic [W-1:0] ae_ofs,
  output logic [W-1:0] af_ofs
);

  logic [W-1:0] ofs_q [2];
  logic [W-1:0] preset;
  ofs_sel_e     ptr_q;

  assign preset = W'(preset_ofs(dflt_sel));

  generate
    for (genvar i = 0; i < 2; i++) begin : g_ofs
      always_ff @(posedge clk) begin
        if (mrst)
          ofs_q[i] <= preset;
        else if (cm_en && (cm_sel == ofs_sel_e'(i)))
          ofs_q[i] <= cm_data;
        else if (wr_en && (ptr_q == ofs_sel_e'(i)))
          ofs_q[i] <= wr_data;
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (mrst || prst) ptr_q <= SEL_AE;
    else if (wr_en)   ptr_q <= (ptr_q == SEL_AE) ? SEL_AF : SEL_AE;
  end

  assign ae_ofs = ofs_q[0];
  assign af_ofs = ofs_q[1];

endmodule

// File: rtl/fop_offset_unit.sv
module fop_offset_unit
  import fop_pkg::*;
#(
  parameter int OFS_W       = 10,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             mrst,
  input  logic             prst,
  input  logic [2:0]       dflt_sel,
  input  logic             ld,
  input  logic             p_valid,
  output logic             p_ready,
  input  logic [OFS_W-1:0] p_data,
  input  logic             sclk,
  input  logic             sen,
  input  logic             sdi,
  output logic [OFS_W-1:0] ae_ofs,
  output logic [OFS_W-1:0] af_ofs
);

  logic [OFS_W-1:0] ser_hold;
  ofs_sel_e         ser_sel;
  logic             ser_req;
  logic             cmt;
  logic             p_take;

  fop_serial_shift #(.W(OFS_W)) u_ser (
    .sclk      (sclk),
    .mrst      (mrst),
    .prst      (prst),
    .ld        (ld),
    .sen       (sen),
    .sdi       (sdi),
    .hold_q    (ser_hold),
    .hold_sel_q(ser_sel),
    .req_q     (ser_req)
  );

  fop_sync_commit #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .mrst     (mrst),
    .prst     (prst),
    .req_async(ser_req),
    .commit   (cmt)
  );

  assign p_ready = !cmt && !mrst && !prst;
  assign p_take  = p_valid && p_ready && ld;

  fop_offset_regs #(.W(OFS_W)) u_regs (
    .clk     (clk),
    .mrst    (mrst),
    .prst    (prst),
    .dflt_sel(dflt_sel),
    .wr_en   (p_take),
    .wr_data (p_data),
    .cm_en   (cmt),
    .cm_sel  (ser_sel),
    .cm_data (ser_hold),
    .ae_ofs  (ae_ofs),
    .af_ofs  (af_ofs)
  );

endmodule

// File: rtl/fop_offset_unit_chk.sv
module fop_offset_unit_chk #(
  parameter int W = 10
) (
  input logic         clk,
  input logic         mrst,
  input logic         prst,
  input logic [2:0]   dflt_sel,
  input logic         ld,
  input logic         p_valid,
  input logic         p_ready,
  input logic [W-1:0] p_data,
  input logic [W-1:0] ae_ofs,
  input logic [W-1:0] af_ofs,
  input logic         cmt,
  input logic [W-1:0] hold_q
);

  logic acc;
  assign acc = p_valid && p_ready && ld;

  AST_PRESET_PAIR: assert property (@(posedge clk)
    mrst |=> (ae_ofs == W'((32'd1 << ({29'd0, $past(dflt_sel)} + 32'd3)) - 32'd1))
          && (af_ofs == ae_ofs)); // R1

  AST_PAR_ONE_TARGET: assert property (@(posedge clk) disable iff (mrst)
    acc |=> ((ae_ofs == $past(p_data)) || (af_ofs == $past(p_data)))
         && ($countones({ae_ofs != $past(ae_ofs), af_ofs != $past(af_ofs)}) <= 1)); // R2

  AST_NO_LD_NO_WRITE: assert property (@(posedge clk) disable iff (mrst)
    (!ld && !cmt) |=> $stable(ae_ofs) && $stable(af_ofs)); // R3

  AST_READY_DROP_COMMIT: assert property (@(posedge clk) disable iff (mrst)
    cmt |-> !p_ready); // R4

  AST_COMMIT_WHOLE_WORD: assert property (@(posedge clk) disable iff (mrst)
    cmt |=> (ae_ofs == $past(hold_q)) || (af_ofs == $past(hold_q))); // R6

  AST_PRST_KEEPS_OFS: assert property (@(posedge clk) disable iff (mrst)
    prst |=> $stable(ae_ofs) && $stable(af_ofs)); // R9

  AST_OFS_ONLY_ON_WRITE: assert property (@(posedge clk) disable iff (mrst)
    (!acc && !cmt) |=> $stable(ae_ofs) && $stable(af_ofs)); // R10

endmodule

bind fop_offset_unit fop_offset_unit_chk #(.W(OFS_W)) u_chk (
  .clk     (clk),
  .mrst    (mrst),
  .prst    (prst),
  .dflt_sel(dflt_sel),
  .ld      (ld),
  .p_valid (p_valid),
  .p_ready (p_ready),
  .p_data  (p_data),
  .ae_ofs  (ae_ofs),
  .af_ofs  (af_ofs),
  .cmt     (cmt),
  .hold_q  (ser_hold)
);

// File: tb/test_fop_offset_unit.sv
module test_fop_offset_unit;

  localparam int W = 10;

  logic         clk = 1'b0;
  logic         mrst = 1'b1;
  logic         prst = 1'b0;
  logic [2:0]   dflt_sel = 3'd0;
  logic         ld = 1'b1;
  logic         p_valid = 1'b0;
  logic         p_ready;
  logic [W-1:0] p_data = '0;
  logic         sclk = 1'b0;
  logic         sen = 1'b0;
  logic         sdi = 1'b0;
  logic [W-1:0] ae_ofs;
  logic [W-1:0] af_ofs;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  fop_offset_unit #(.OFS_W(W)) i_fop_offset_unit (
    .clk(clk), .mrst(mrst), .prst(prst), .dflt_sel(dflt_sel), .ld(ld),
    .p_valid(p_valid), .p_ready(p_ready), .p_data(p_data),
    .sclk(sclk), .sen(sen), .sdi(sdi), .ae_ofs(ae_ofs), .af_ofs(af_ofs)
  );

  always #4 clk = ~clk;

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic do_mrst(input logic [2:0] s);
    @(negedge clk);
    dflt_sel = s;
    mrst = 1'b1;
    wait_clk(2);
    mrst = 1'b0;
  endtask

  task automatic do_prst();
    @(negedge clk);
    prst = 1'b1;
    @(negedge clk);
    prst = 1'b0;
  endtask

  task automatic pwrite(input logic [W-1:0] d);
    p_valid = 1'b1;
    p_data = d;
    @(negedge clk);
    p_valid = 1'b0;
  endtask

  // shift n bits of v, bit 0 first, with given sen
  task automatic sbits(input logic [W-1:0] v, input int n, input logic en);
    sen = en;
    for (int i = 0; i < n; i++) begin
      sdi = v[i];
      #10 sclk = 1'b1;
      #10 sclk = 1'b0;
    end
    sen = 1'b0;
  endtask

  // watch the commit window: single-step update and ready drops
  task automatic watch(input logic ae_side, input logic [W-1:0] oldv,
                       input logic [W-1:0] newv, input string req);
    int bad = 0;
    int lows = 0;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      if (!p_ready) lows++;
      if (ae_side ? (ae_ofs != oldv && ae_ofs != newv)
                  : (af_ofs != oldv && af_ofs != newv)) bad++;
    end
    check({req, " R6 no partial value"}, bad, 0);
    check({req, " R4 one ready drop"}, lows, 1);
    check({req, " R5 value"}, ae_side ? ae_ofs : af_ofs, newv);
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    // R1: every preset, computed arithmetically
    for (int s = 0; s < 8; s++) begin
      do_mrst(3'(s));
      check("R1 ae preset", ae_ofs, (1 << (s + 3)) - 1);
      check("R1 af preset", af_ofs, (1 << (s + 3)) - 1);
    end
    @(negedge clk);
    mrst = 1'b1;
    #1 check("R4 ready low in mrst", p_ready, 0);
    wait_clk(1);
    mrst = 1'b0;
    #1 check("R4 ready high idle", p_ready, 1);

    // R2: alternation and wrap, back to back
    do_mrst(3'd0);
    pwrite(10'd100);
    check("R2 first to ae", ae_ofs, 100);
    check("R2 af untouched", af_ofs, 7);
    pwrite(10'd200);
    check("R2 second to af", af_ofs, 200);
    pwrite(10'd300);
    check("R2 wrap to ae", ae_ofs, 300);
    check("R2 af after wrap", af_ofs, 200);

    // R3: valid without ld, pointer must stay at af
    ld = 1'b0;
    p_valid = 1'b1;
    p_data = 10'd555;
    wait_clk(3);
    p_valid = 1'b0;
    check("R3 ae kept", ae_ofs, 300);
    check("R3 af kept", af_ofs, 200);
    ld = 1'b1;
    pwrite(10'd400);
    check("R3 pointer not advanced", af_ofs, 400);

    // R9: partial reset keeps values, pointer back to ae
    @(negedge clk);
    prst = 1'b1;
    #1 check("R4 ready low in prst", p_ready, 0);
    @(negedge clk);
    prst = 1'b0;
    check("R9 ae kept", ae_ofs, 300);
    check("R9 af kept", af_ofs, 400);
    pwrite(10'd11);
    check("R9 pointer to ae", ae_ofs, 11);
    check("R9 af unchanged", af_ofs, 400);

    // R5/R6/R4: serial load into both
    do_mrst(3'd3);
    sbits(10'h2A5, W, 1'b1);
    watch(1'b1, 10'd63, 10'h2A5, "ser ae");
    check("R5 af untouched", af_ofs, 63);
    sbits(10'h15A, W, 1'b1);
    watch(1'b0, 10'd63, 10'h15A, "ser af");

    // R7: further bits ignored
    sbits(10'h3FF, W, 1'b1);
    wait_clk(8);
    check("R7 ae kept", ae_ofs, 'h2A5);
    check("R7 af kept", af_ofs, 'h15A);

    // R9: prst rearms serial count
    do_prst();
    check("R9 serial prst keeps ae", ae_ofs, 'h2A5);
    sbits(10'h0F0, W, 1'b1);
    wait_clk(8);
    check("R9 serial restarts at ae", ae_ofs, 'h0F0);

    // R8: sen low, then ld low: edges ignored, count not advanced
    sbits(10'h3FF, W, 1'b0);
    ld = 1'b0;
    sbits(10'h3FF, 3, 1'b1);
    ld = 1'b1;
    wait_clk(8);
    check("R8 ae kept", ae_ofs, 'h0F0);
    check("R8 af kept", af_ofs, 'h15A);
    sbits(10'h123, W, 1'b1);
    wait_clk(8);
    check("R8 count intact, af next", af_ofs, 'h123);
    check("R8 ae still", ae_ofs, 'h0F0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule